// File: doc/BRIEF.md
# Three-share masked 3-bit substitution layer

This block applies a bit-sliced 3-bit substitution to three data words at once, x0, x1 and x2. Bit position i of the three words forms one 3-bit input. The data are never handled in unmasked form inside the datapath. Each word is first split into three Boolean shares using two caller-supplied random words. The substitution is computed in a serial chain: y0 first, then y1 from y0, then y2 from y0 and y1. At the end the three shares of each result word are recombined by XOR. The random words come in through ports, because generating randomness is outside this block.

Every output share of every stage is the XOR of three component functions. Each component is wired to only two of the three share indices, which keeps the computation non-complete. Each stage ends in a register bank, so that a glitch in one stage cannot reach a later stage and combine shares there. A valid/ready handshake moves the pipeline forward as a whole. When the random inputs are held constant the results are still correct and only the masking protection is lost.

Top module: `tmask_sbox_layer`

## Requirements
- R1: While and after `rst` is high, `out_valid` is low and `in_ready` is high until the first accepted input reaches the output.
- R2: An input is accepted in a cycle where `in_valid` and `in_ready` are both high. With `out_ready` held high, its result is presented with `out_valid` high exactly four cycles after the cycle of acceptance.
- R3: Every bit position is independent. For each bit: y0 = x0 ^ (x1 | ~x2), then y1 = x1 ^ (x2 | y0), then y2 = x2 ^ (y0 | ~y1).
- R4: The result does not depend on the mask inputs, including all-zero and all-one masks. Word k (x0, x1, x2 for k = 0, 1, 2) takes its two masks from bits [k*W +: W] of `in_mask_a` and `in_mask_b`.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_y0`, `out_y1` and `out_y2` hold their values and `in_ready` is low.
- R6: With `out_ready` high, inputs accepted on consecutive cycles produce results on consecutive cycles, in the order of acceptance.
- R7: Cycles without an accepted input produce no result. The number of results equals the number of accepted inputs.
- R8: `in_valid` raised while `in_ready` is low is ignored, and the data presented in that cycle never appear as a result.
- R9: The mapping is a permutation. The eight 3-bit input patterns at eight bit positions give eight distinct output patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input words and masks are valid |
| in_ready | output | 1 | The pipeline can take an input this cycle |
| in_x0 | input | W | Data word x0 |
| in_x1 | input | W | Data word x1 |
| in_x2 | input | W | Data word x2 |
| in_mask_a | input | 3*W | First random mask, one W-bit field per data word |
| in_mask_b | input | 3*W | Second random mask, one W-bit field per data word |
| out_valid | output | 1 | Result words are valid |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_y0 | output | W | Result word y0 |
| out_y1 | output | W | Result word y1 |
| out_y2 | output | W | Result word y2 |

## Verification
The bench builds the block at its default W = 32. This puts the full 32-bit slice width in play: random words exercise all 32 lanes at once, and all eight 3-bit patterns fit in the low byte for the permutation check. Masks are driven as fresh random words and also as constant all-zero and all-one values, so a wrong cross-term assignment in a component shows up as a wrong recombined result. Stall, gap and back-to-back scenarios cover the handshake.

// File: rtl/tmask_pkg.sv
package tmask_pkg;
  // number of Boolean shares; degree-2 function needs degree+1
  localparam int NSH = 3;

  // shape of the nonlinear term: p ^ (q | r) or p ^ (q | ~r)
  typedef enum logic [0:0] {
    GATE_OR  = 1'b0,
    GATE_ORN = 1'b1
  } gate_e;
endpackage

// File: rtl/tmask_split.sv
module tmask_split
  import tmask_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]          x,
  input  logic [W-1:0]          m_a,
  input  logic [W-1:0]          m_b,
  output logic [NSH-1:0][W-1:0] sh
);
  // two shares are the masks themselves, the third carries the data
  assign sh[0] = m_a;
  assign sh[1] = m_b;
  assign sh[2] = x ^ m_a ^ m_b;
endmodule

// File: rtl/tmask_comp.sv
module tmask_comp
  import tmask_pkg::*;
#(
  parameter int    W       = 32,
  parameter gate_e GATE    = GATE_OR,
  parameter bit    ADD_ONE = 1'b0
) (
  // share "u" contributes only to cross products, share "v" fully
  input  logic [W-1:0] u_q,
  input  logic [W-1:0] u_r,
  input  logic [W-1:0] v_p,
  input  logic [W-1:0] v_q,
  input  logic [W-1:0] v_r,
  output logic [W-1:0] f
);
  logic [W-1:0] lin;
  logic [W-1:0] cst;

  // q|r = q^r^qr ; q|~r = 1^r^qr
  generate
    if (GATE == GATE_ORN) begin : g_orn
      assign lin = v_p ^ v_r;
    end else begin : g_or
      assign lin = v_p ^ v_q ^ v_r;
    end
  endgenerate

  assign cst = ADD_ONE ? {W{1'b1}} : '0;
  assign f   = lin ^ (u_q & v_r) ^ (v_q & u_r) ^ (v_q & v_r) ^ cst;
endmodule

// File: rtl/tmask_stage.sv
module tmask_stage
  import tmask_pkg::*;
#(
  parameter int    W    = 32,
  parameter gate_e GATE = GATE_OR
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [NSH-1:0][W-1:0] p_sh,
  input  logic [NSH-1:0][W-1:0] q_sh,
  input  logic [NSH-1:0][W-1:0] r_sh,
  output logic [NSH-1:0][W-1:0] y_sh
);
  logic [NSH-1:0][W-1:0] comp_w;

  // component k sees share k and share k+1 only
  generate
    for (genvar k = 0; k < NSH; k++) begin : g_comp
      tmask_comp #(
        .W      (W),
        .GATE   (GATE),
        .ADD_ONE((GATE == GATE_ORN) && (k == 1))
      ) u_comp (
        .u_q(q_sh[k]),
        .u_r(r_sh[k]),
        .v_p(p_sh[(k+1)%NSH]),
        .v_q(q_sh[(k+1)%NSH]),
        .v_r(r_sh[(k+1)%NSH]),
        .f  (comp_w[k])
      );
    end
  endgenerate

  // register wall between stages stops glitches mixing shares
  always_ff @(posedge clk) begin
    if (rst)     y_sh <= '0;
    else if (en) y_sh <= comp_w;
  end

  // unmasked view, used only to check the shared computation
  logic [W-1:0] p_u, q_u, r_u, y_u, ref_u;
  always_comb begin
    p_u = '0; q_u = '0; r_u = '0; y_u = '0;
    for (int k = 0; k < NSH; k++) begin
      p_u ^= p_sh[k];
      q_u ^= q_sh[k];
      r_u ^= r_sh[k];
      y_u ^= y_sh[k];
    end
    ref_u = (GATE == GATE_ORN) ? (p_u ^ (q_u | ~r_u)) : (p_u ^ (q_u | r_u));
  end

  // R3: recombined stage output equals the unmasked gate of the inputs
  p_unmasked_match_r3: assert property (@(posedge clk) disable iff (rst)
    en |=> (y_u == $past(ref_u)));
endmodule

// File: rtl/tmask_sbox_layer.sv
module tmask_sbox_layer
  import tmask_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_x0,
  input  logic [W-1:0]   in_x1,
  input  logic [W-1:0]   in_x2,
  input  logic [3*W-1:0] in_mask_a,
  input  logic [3*W-1:0] in_mask_b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_y0,
  output logic [W-1:0]   out_y1,
  output logic [W-1:0]   out_y2
);
  localparam int NWORD = 3;
  localparam int NSTG  = 3;

  logic en;
  assign en       = out_ready || !out_valid;
  assign in_ready = en;

  // ---------------- share splitting ----------------
  logic [NWORD-1:0][W-1:0]          x_w;
  logic [NWORD-1:0][NSH-1:0][W-1:0] x_sh;
  assign x_w = {in_x2, in_x1, in_x0};

  generate
    for (genvar w = 0; w < NWORD; w++) begin : g_split
      tmask_split #(.W(W)) u_split (
        .x  (x_w[w]),
        .m_a(in_mask_a[w*W +: W]),
        .m_b(in_mask_b[w*W +: W]),
        .sh (x_sh[w])
      );
    end
  endgenerate

  // ---------------- stage 1: y0 ----------------
  logic [NSH-1:0][W-1:0] y0_s1, c1_x1, c1_x2;
  tmask_stage #(.W(W), .GATE(GATE_ORN)) u_stg_y0 (
    .clk(clk), .rst(rst), .en(en),
    .p_sh(x_sh[0]), .q_sh(x_sh[1]), .r_sh(x_sh[2]),
    .y_sh(y0_s1)
  );

  // ---------------- stage 2: y1 ----------------
  logic [NSH-1:0][W-1:0] y1_s2, y0_s2, c2_x2;
  tmask_stage #(.W(W), .GATE(GATE_OR)) u_stg_y1 (
    .clk(clk), .rst(rst), .en(en),
    .p_sh(c1_x1), .q_sh(c1_x2), .r_sh(y0_s1),
    .y_sh(y1_s2)
  );

  // ---------------- stage 3: y2 ----------------
  logic [NSH-1:0][W-1:0] y2_s3, y0_s3, y1_s3;
  tmask_stage #(.W(W), .GATE(GATE_ORN)) u_stg_y2 (
    .clk(clk), .rst(rst), .en(en),
    .p_sh(c2_x2), .q_sh(y0_s2), .r_sh(y1_s2),
    .y_sh(y2_s3)
  );

  // shares carried alongside the stages
  always_ff @(posedge clk) begin
    if (rst) begin
      c1_x1 <= '0; c1_x2 <= '0;
      y0_s2 <= '0; c2_x2 <= '0;
      y0_s3 <= '0; y1_s3 <= '0;
    end else if (en) begin
      c1_x1 <= x_sh[1]; c1_x2 <= x_sh[2];
      y0_s2 <= y0_s1;   c2_x2 <= c1_x2;
      y0_s3 <= y0_s2;   y1_s3 <= y1_s2;
    end
  end

  // ---------------- recombination ----------------
  logic [W-1:0] rec0, rec1, rec2;
  always_comb begin
    rec0 = '0; rec1 = '0; rec2 = '0;
    for (int k = 0; k < NSH; k++) begin
      rec0 ^= y0_s3[k];
      rec1 ^= y1_s3[k];
      rec2 ^= y2_s3[k];
    end
  end

  // ---------------- valid pipeline and output ----------------
  logic [NSTG-1:0] vld;
  always_ff @(posedge clk) begin
    if (rst) begin
      vld       <= '0;
      out_valid <= 1'b0;
      out_y0    <= '0;
      out_y1    <= '0;
      out_y2    <= '0;
    end else if (en) begin
      vld       <= {vld[NSTG-2:0], in_valid};
      out_valid <= vld[NSTG-1];
      out_y0    <= rec0;
      out_y1    <= rec1;
      out_y2    <= rec2;
    end
  end

  // R1: reset empties the pipeline
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && (vld == '0)));

  // R2: an accepted input enters the first stage
  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> vld[0]);

  // R5: a stalled result is held
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_y0)
                                   && $stable(out_y1) && $stable(out_y2)));

  // R7: no input, no token
  p_bubble_r7: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> !vld[0]);

  // R8: nothing moves while input is refused
  p_no_accept_r8: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> $stable(vld));
endmodule

// File: tb/test_tmask_sbox_layer.sv
module test_tmask_sbox_layer;
  localparam int W = 32;
  localparam int NLOG = 256;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [W-1:0]   in_x0 = '0, in_x1 = '0, in_x2 = '0;
  logic [3*W-1:0] in_mask_a = '0, in_mask_b = '0;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic [W-1:0]   out_y0, out_y1, out_y2;

  always #4 clk = ~clk;  // 125 MHz

  tmask_sbox_layer #(.W(W)) i_tmask_sbox_layer (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_x0(in_x0), .in_x1(in_x1), .in_x2(in_x2),
    .in_mask_a(in_mask_a), .in_mask_b(in_mask_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_y0(out_y0), .out_y1(out_y1), .out_y2(out_y2)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  function automatic logic [3*W-1:0] sbox_ref(input logic [W-1:0] a0, a1, a2);
    logic [W-1:0] b0, b1, b2;
    b0 = a0 ^ (a1 | ~a2);
    b1 = a1 ^ (a2 | b0);
    b2 = a2 ^ (b0 | ~b1);
    return {b2, b1, b0};
  endfunction

  // logs of accepted inputs (with expected results) and delivered results
  logic [3*W-1:0] exp_log [NLOG];
  logic [3*W-1:0] got_log [NLOG];
  int acc_cyc [NLOG];
  int out_cyc [NLOG];
  int acc_n = 0, out_n = 0, cyc = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst && in_valid && in_ready && acc_n < NLOG) begin
      exp_log[acc_n] = sbox_ref(in_x0, in_x1, in_x2);
      acc_cyc[acc_n] = cyc;
      acc_n++;
    end
    if (!rst && out_valid && out_ready && out_n < NLOG) begin
      got_log[out_n] = {out_y2, out_y1, out_y0};
      out_cyc[out_n] = cyc;
      out_n++;
    end
  end

  task automatic chk(input string req, input logic [3*W-1:0] act, input logic [3*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic push(input logic [W-1:0] a0, a1, a2, input logic [3*W-1:0] ma, mb);
    in_x0 = a0; in_x1 = a1; in_x2 = a2;
    in_mask_a = ma; in_mask_b = mb;
    in_valid = 1'b1;
    tick();
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) tick();
  endtask

  function automatic logic [3*W-1:0] rnd3();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  // compare results from index base, count entries; checks value and latency
  task automatic verify(input int base, input int cnt, input string req);
    chk({req, " count"}, 3*W'(out_n - base), 3*W'(cnt));
    for (int i = base; i < base + cnt && i < out_n && i < acc_n; i++) begin
      chk({req, " R3 value"}, got_log[i], exp_log[i]);
      chk({req, " R2 latency"}, 3*W'(out_cyc[i] - acc_cyc[i]), 3*W'(4));
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    chk("R1 out_valid in reset", 3*W'(out_valid), '0);
    rst = 1'b0;
    tick();
    chk("R1 out_valid after reset", 3*W'(out_valid), '0);
    chk("R1 in_ready after reset", 3*W'(in_ready), 3*W'(1));
    chk("R1 no results", 3*W'(out_n), '0);
  endtask

  task automatic t_single();
    int base;
    base = acc_n;
    push(32'h1234_5678, 32'h9abc_def0, 32'h0f0f_a5a5, rnd3(), rnd3());
    idle(2);
    chk("R2 not early", 3*W'(out_n - base), '0);
    idle(6);
    verify(base, 1, "R2 single");
    base = acc_n;
    for (int i = 0; i < 8; i++) begin
      push($urandom(), $urandom(), $urandom(), rnd3(), rnd3());
      idle(5);
    end
    verify(base, 8, "R3 random");
  endtask

  task automatic t_masks();
    int base;
    logic [W-1:0] a0, a1, a2;
    a0 = 32'hdead_beef; a1 = 32'h0123_4567; a2 = 32'hcafe_f00d;
    base = acc_n;
    push(a0, a1, a2, '0, '0);
    push(a0, a1, a2, '1, '1);
    push(a0, a1, a2, '1, '0);
    push(a0, a1, a2, rnd3(), rnd3());
    idle(8);
    verify(base, 4, "R4 masks");
    for (int i = base + 1; i < base + 4 && i < out_n; i++)
      chk("R4 same result", got_log[i], got_log[base]);
  endtask

  task automatic t_perm();
    int base;
    logic [7:0] seen;
    logic [2:0] pat;
    base = acc_n;
    push({$urandom()} & 32'hffff_ff00 | 32'h0000_00aa,
         {$urandom()} & 32'hffff_ff00 | 32'h0000_00cc,
         {$urandom()} & 32'hffff_ff00 | 32'h0000_00f0, rnd3(), rnd3());
    idle(8);
    verify(base, 1, "R9 perm");
    seen = '0;
    if (out_n > base) begin
      for (int j = 0; j < 8; j++) begin
        pat = {got_log[base][2*W + j], got_log[base][W + j], got_log[base][j]};
        seen[pat] = 1'b1;
      end
    end
    chk("R9 distinct outputs", 3*W'(seen), 3*W'(8'hff));
  endtask

  task automatic t_burst();
    int base;
    base = acc_n;
    in_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      in_x0 = $urandom(); in_x1 = $urandom(); in_x2 = $urandom();
      in_mask_a = rnd3(); in_mask_b = rnd3();
      tick();
    end
    idle(8);
    verify(base, 6, "R6 burst");
    for (int i = base; i < base + 5 && i + 1 < out_n; i++)
      chk("R6 consecutive", 3*W'(out_cyc[i+1] - out_cyc[i]), 3*W'(1));
  endtask

  task automatic t_gaps();
    int base;
    base = acc_n;
    push($urandom(), $urandom(), $urandom(), rnd3(), rnd3());
    idle(2);
    push($urandom(), $urandom(), $urandom(), rnd3(), rnd3());
    idle(1);
    push($urandom(), $urandom(), $urandom(), rnd3(), rnd3());
    idle(10);
    verify(base, 3, "R7 gaps");
    chk("R7 accepted count", 3*W'(acc_n - base), 3*W'(3));
  endtask

  task automatic t_stall();
    int base;
    logic [3*W-1:0] expv, held;
    base = acc_n;
    out_ready = 1'b0;
    push(32'h5555_aaaa, 32'h3333_cccc, 32'h0ff0_f00f, rnd3(), rnd3());
    expv = sbox_ref(32'h5555_aaaa, 32'h3333_cccc, 32'h0ff0_f00f);
    idle(6);
    chk("R5 valid while stalled", 3*W'(out_valid), 3*W'(1));
    chk("R5 in_ready low", 3*W'(in_ready), '0);
    held = {out_y2, out_y1, out_y0};
    chk("R5 stalled value", held, expv);
    // offer other data while refused
    in_x0 = 32'hffff_0000; in_x1 = 32'h0000_ffff; in_x2 = 32'h1111_1111;
    in_valid = 1'b1;
    repeat (3) begin
      tick();
      chk("R5 held", {out_y2, out_y1, out_y0}, held);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    idle(10);
    chk("R8 one result only", 3*W'(out_n - base), 3*W'(1));
    if (out_n > base) chk("R8 result is original", got_log[base], expv);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_masks();
    t_perm();
    t_burst();
    t_gaps();
    t_stall();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule